// File: doc/BRIEF.md
# Quasi-Resonant Gate Timing Controller

This block is the clocked timing core of a flyback converter that runs in critical conduction. It decides, cycle by cycle, when the power switch gate is driven on and when it is released. The analog side is seen only through digital flags. These are a raw zero-crossing input from the transformer valley detector, a current-limit comparator flag, an under-voltage lockout flag and an over-temperature flag. The over-temperature flag already carries its own hysteresis.

A conduction interval begins on a synchronized rising edge of the zero-crossing input. During a leading-edge blanking window the current-limit flag is not looked at, and this window sets the minimum on-time. Once blanking is over, the current-limit flag ends conduction. A minimum off-time then caps the switching frequency. Any zero-crossing edge that arrives while the off-time runs is thrown away. The off-time is selected by a two-bit clamp mode: disabled (pure critical conduction), a fixed default, or an adjustable count taken from an input word.

Either fault flag forces the gate low at once and parks the controller in IDLE. After the fault clears, the controller waits for a fresh zero-crossing edge. If none comes within a restart timeout, it starts a conduction interval by itself.

Top module: `qr_gate_timer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `gate_on` is 0 and `fsm_state` reads IDLE. The state codes are IDLE=0, ON_BLANK=1, ON=2, OFF_MIN=3, WAIT_ZCD=4, and no other code appears.
- R2: A rising edge on `zcd_raw` passes through a two-flop synchronizer and an edge detector. When the raw input rises just before clock edge k, with the controller in IDLE or WAIT_ZCD and no fault, `fsm_state` becomes ON_BLANK after edge k+2. `gate_on` is 1 in ON_BLANK and ON.
- R3: During the first BLANK_CYC clock cycles of gate-high time, `cs_trip` is ignored. The gate therefore stays high for at least BLANK_CYC cycles, even when `cs_trip` is high all through the blanking window.
- R4: After blanking, a high `cs_trip` sampled by a clock edge drives the gate low from that edge on. With `cs_trip` raised in gate-high cycle n > BLANK_CYC, the on-time is exactly n cycles.
- R5: The off-time counter starts in the first cycle with the gate low, and OFF_MIN lasts exactly the selected number of cycles. The off-time is chosen by `clamp_mode` at turn-off: 00 gives zero (OFF_MIN is skipped and WAIT_ZCD is entered directly), 01 and 11 give FIXED_OFF cycles, and 10 gives `off_adj` cycles.
- R6: A zero-crossing edge that arrives during OFF_MIN, including one in its last cycles, is dropped. After OFF_MIN the controller sits in WAIT_ZCD with the gate low until a new edge arrives.
- R7: In WAIT_ZCD, a new zero-crossing edge starts the next conduction interval (ON_BLANK).
- R8: While `uvlo` is 1, `gate_on` is 0 in the same cycle, the state goes to IDLE at the next edge, and zero-crossing edges are ignored.
- R9: While `otp` is 1, the behaviour is the same as R8: the gate is low at once and the state goes to IDLE.
- R10: In IDLE with no fault, a zero-crossing edge starts ON_BLANK. If no edge arrives, ON_BLANK starts on the RESTART_CYC-th fault-free clock edge spent in IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| zcd_raw | input | 1 | Asynchronous zero-crossing detector output |
| cs_trip | input | 1 | Current-limit comparator flag |
| uvlo | input | 1 | Under-voltage lockout flag, active high |
| otp | input | 1 | Over-temperature flag (already hysteretic), active high |
| clamp_mode | input | 2 | Frequency clamp select: 00 off, 01/11 fixed, 10 adjustable |
| off_adj | input | CNT_W | Off-time in clock cycles for the adjustable mode |
| gate_on | output | 1 | Gate drive enable |
| fsm_state | output | 3 | Current controller state code |

## Verification
A zero-crossing edge can fall in the same cycle as the end of the minimum off-time. A fault flag can fall in the same cycle as a conduction start or a current-limit trip. The bench raises the zero-crossing input a few cycles before a fixed off-time expires, so that the synchronized edge reaches the state machine inside the last OFF_MIN cycles. The state must then be WAIT_ZCD with the gate low, and it must still be so twenty cycles later. It also raises lockout and over-temperature during conduction and checks that the gate is already low in the same cycle, before the next clock edge. A zero-crossing edge given while lockout is held must leave the state in IDLE.

// File: rtl/qrc_pkg.sv
package qrc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_ON_BLANK = 3'd1,
        ST_ON       = 3'd2,
        ST_OFF_MIN  = 3'd3,
        ST_WAIT_ZCD = 3'd4
    } qrc_state_e;

    typedef enum logic [1:0] {
        CLAMP_NONE  = 2'b00,
        CLAMP_FIXED = 2'b01,
        CLAMP_ADJ   = 2'b10,
        CLAMP_ALT   = 2'b11
    } clamp_mode_e;

endpackage

// File: rtl/zcd_edge.sv
module zcd_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic rise_pulse
);
    // The stages are the synchronizer, then one extra flop that holds the previous value.
    logic [SYNC_STAGES:0] sh_q;
    logic [SYNC_STAGES:0] sh_d;

    always_comb begin
        sh_d = {sh_q[SYNC_STAGES-1:0], raw_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise_pulse = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
endmodule

// File: rtl/off_time_mux.sv
module off_time_mux
    import qrc_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int FIXED_OFF = 690
) (
    input  logic [1:0]       mode,
    input  logic [CNT_W-1:0] adj_len,
    output logic [CNT_W-1:0] off_len
);
    localparam logic [CNT_W-1:0] FIXED_LEN = CNT_W'(FIXED_OFF);

    always_comb begin
        unique case (clamp_mode_e'(mode))
            CLAMP_NONE: off_len = '0;
            CLAMP_ADJ:  off_len = adj_len;
            default:    off_len = FIXED_LEN;
        endcase
    end
endmodule

// File: rtl/restart_watch.sv
module restart_watch #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    output logic fire
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_d;

    always_comb begin
        if (!armed)           cnt_d = '0;
        else if (cnt_q == LAST) cnt_d = cnt_q;
        else                  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign fire = armed && (cnt_q == LAST);
endmodule

// File: rtl/qr_gate_timer.sv
module qr_gate_timer
    import qrc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int BLANK_CYC   = 25,
    parameter int FIXED_OFF   = 690,
    parameter int RESTART_CYC = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             zcd_raw,
    input  logic             cs_trip,
    input  logic             uvlo,
    input  logic             otp,
    input  logic [1:0]       clamp_mode,
    input  logic [CNT_W-1:0] off_adj,
    output logic             gate_on,
    output logic [2:0]       fsm_state
);
    localparam logic [CNT_W-1:0] BLANK_LOAD = CNT_W'(BLANK_CYC - 1);

    typedef struct packed {
        qrc_state_e       st;
        logic [CNT_W-1:0] tmr;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic             zcd_rise;
    logic             restart_fire;
    logic             fault;
    logic [CNT_W-1:0] off_len;

    assign fault = uvlo | otp;

    zcd_edge #(.SYNC_STAGES(SYNC_STAGES)) u_zcd (
        .clk        (clk),
        .rst_n      (rst_n),
        .raw_in     (zcd_raw),
        .rise_pulse (zcd_rise)
    );

    off_time_mux #(.CNT_W(CNT_W), .FIXED_OFF(FIXED_OFF)) u_off (
        .mode    (clamp_mode),
        .adj_len (off_adj),
        .off_len (off_len)
    );

    restart_watch #(.LIMIT(RESTART_CYC)) u_rst_watch (
        .clk   (clk),
        .rst_n (rst_n),
        .armed ((ctl_q.st == ST_IDLE) && !fault),
        .fire  (restart_fire)
    );

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (zcd_rise || restart_fire) begin
                    ctl_d.st  = ST_ON_BLANK;
                    ctl_d.tmr = BLANK_LOAD;
                end
            end
            ST_ON_BLANK: begin
                if (ctl_q.tmr != '0) begin
                    ctl_d.tmr = ctl_q.tmr - 1'b1;
                end else if (cs_trip) begin
                    ctl_d.st  = (off_len == '0) ? ST_WAIT_ZCD : ST_OFF_MIN;
                    ctl_d.tmr = off_len - 1'b1;
                end else begin
                    ctl_d.st  = ST_ON;
                end
            end
            ST_ON: begin
                if (cs_trip) begin
                    ctl_d.st  = (off_len == '0) ? ST_WAIT_ZCD : ST_OFF_MIN;
                    ctl_d.tmr = off_len - 1'b1;
                end
            end
            ST_OFF_MIN: begin
                // Zero-crossing edges are deliberately not consulted here.
                if (ctl_q.tmr == '0) ctl_d.st  = ST_WAIT_ZCD;
                else                 ctl_d.tmr = ctl_q.tmr - 1'b1;
            end
            ST_WAIT_ZCD: begin
                if (zcd_rise) begin
                    ctl_d.st  = ST_ON_BLANK;
                    ctl_d.tmr = BLANK_LOAD;
                end
            end
            default: begin
                ctl_d.st  = ST_IDLE;
                ctl_d.tmr = '0;
            end
        endcase
        if (fault) begin
            ctl_d.st  = ST_IDLE;
            ctl_d.tmr = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st  <= ST_IDLE;
            ctl_q.tmr <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign gate_on   = ((ctl_q.st == ST_ON_BLANK) || (ctl_q.st == ST_ON)) && !fault;
    assign fsm_state = ctl_q.st;
endmodule

// File: rtl/qrc_checker.sv
module qrc_checker #(
    parameter int BLANK_CYC = 25
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_trip,
    input logic       uvlo,
    input logic       otp,
    input logic       gate_on,
    input logic [2:0] fsm_state
);
    localparam logic [15:0] BLANK_N = 16'(BLANK_CYC);

    logic [15:0] blk_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                blk_cnt <= '0;
        else if (fsm_state == 3'd1) blk_cnt <= blk_cnt + 16'd1;
        else                       blk_cnt <= '0;
    end

    a_r1_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_state <= 3'd4);

    a_r3_blank_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == 3'd1) |-> (blk_cnt < BLANK_N));

    a_r3_blank_full: assert property (@(posedge clk) disable iff (!rst_n)
        ((fsm_state inside {3'd2, 3'd3, 3'd4}) && blk_cnt != 16'd0) |-> (blk_cnt == BLANK_N));

    a_r4_cs_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == 3'd2 && cs_trip && !uvlo && !otp) |=> (fsm_state inside {3'd0, 3'd3, 3'd4}));

    a_r6_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == 3'd3) |=> (fsm_state inside {3'd0, 3'd3, 3'd4}));

    a_r7_wait_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == 3'd4) |=> (fsm_state inside {3'd0, 3'd1, 3'd4}));

    a_r8_uvlo_low: assert property (@(posedge clk) disable iff (!rst_n)
        uvlo |-> !gate_on);

    a_r8_uvlo_idle: assert property (@(posedge clk) disable iff (!rst_n)
        uvlo |=> (fsm_state == 3'd0));

    a_r9_otp_low: assert property (@(posedge clk) disable iff (!rst_n)
        otp |-> !gate_on);

    a_r9_otp_idle: assert property (@(posedge clk) disable iff (!rst_n)
        otp |=> (fsm_state == 3'd0));
endmodule

bind qr_gate_timer qrc_checker #(.BLANK_CYC(BLANK_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_trip   (cs_trip),
    .uvlo      (uvlo),
    .otp       (otp),
    .gate_on   (gate_on),
    .fsm_state (fsm_state)
);

// File: tb/tb_qr_gate_timer.sv
`timescale 1ns/1ps
module tb_qr_gate_timer;
    localparam int CNT_W       = 16;
    localparam int BLANK_CYC   = 25;
    localparam int FIXED_OFF   = 690;
    localparam int RESTART_CYC = 1000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             zcd_raw = 1'b0;
    logic             cs_trip = 1'b0;
    logic             uvlo = 1'b0;
    logic             otp = 1'b0;
    logic [1:0]       clamp_mode = 2'b00;
    logic [CNT_W-1:0] off_adj = '0;
    logic             gate_on;
    logic [2:0]       fsm_state;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    qr_gate_timer #(
        .CNT_W(CNT_W), .BLANK_CYC(BLANK_CYC), .FIXED_OFF(FIXED_OFF), .RESTART_CYC(RESTART_CYC)
    ) dut (
        .clk(clk), .rst_n(rst_n), .zcd_raw(zcd_raw), .cs_trip(cs_trip), .uvlo(uvlo), .otp(otp),
        .clamp_mode(clamp_mode), .off_adj(off_adj), .gate_on(gate_on), .fsm_state(fsm_state)
    );

    // Each row: clamp mode, adjustable length, cycle cs is raised, expected on-time, expected off-time
    localparam int NVEC = 6;
    localparam int VEC [NVEC][5] = '{
        '{1,  0, 40, 40, FIXED_OFF},
        '{0,  0, 30, 30, 0},
        '{2, 40, 10, BLANK_CYC, 40},
        '{2,  0, 50, 50, 0},
        '{3,  5, BLANK_CYC, BLANK_CYC, FIXED_OFF},
        '{2,  1, 26, 26, 1}
    };

    task automatic check(string req, int act, int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wait_gate(int lim);
        for (int i = 0; i < lim && !gate_on; i++) step();
    endtask

    // Runs one conduction period; returns the measured on and off lengths.
    task automatic run_period(int cs_at, output int on_len, output int off_len);
        zcd_raw = 1'b1;
        wait_gate(20);
        zcd_raw = 1'b0;
        on_len = 0;
        while (gate_on && on_len < 5000) begin
            on_len++;
            if (on_len == cs_at) cs_trip = 1'b1;
            step();
        end
        cs_trip = 1'b0;
        off_len = 0;
        while (fsm_state == 3'd3 && off_len < 5000) begin
            off_len++;
            step();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        int on_l, off_l;
        step();
        check("R1 gate in reset", int'(gate_on), 0);
        check("R1 state in reset", int'(fsm_state), 0);
        step();
        rst_n = 1'b1;
        step();
        check("R1 gate after reset", int'(gate_on), 0);
        check("R1 state after reset", int'(fsm_state), 0);

        // R2: latency of the synchronized zero-crossing edge
        zcd_raw = 1'b1;
        step();
        step();
        check("R2 no start before sync", int'(fsm_state), 0);
        step();
        check("R2 state ON_BLANK", int'(fsm_state), 1);
        check("R2 gate high", int'(gate_on), 1);
        zcd_raw = 1'b0;
        clamp_mode = 2'b00;
        cs_trip = 1'b1;
        while (gate_on) step();
        cs_trip = 1'b0;
        check("R5 mode 00 goes to WAIT_ZCD", int'(fsm_state), 4);

        // R3 R4 R5: table of periods
        for (int v = 0; v < NVEC; v++) begin
            clamp_mode = 2'(VEC[v][0]);
            off_adj = CNT_W'(VEC[v][1]);
            run_period(VEC[v][2], on_l, off_l);
            check($sformatf("R3/R4 on-time row %0d", v), on_l, VEC[v][3]);
            check($sformatf("R5 off-time row %0d", v), off_l, VEC[v][4]);
            check($sformatf("R7 WAIT_ZCD row %0d", v), int'(fsm_state), 4);
        end

        // R6: zero-crossing edges during the fixed off-time are dropped
        clamp_mode = 2'b01;
        zcd_raw = 1'b1;
        wait_gate(20);
        zcd_raw = 1'b0;
        cs_trip = 1'b1;
        while (gate_on) step();
        cs_trip = 1'b0;
        off_l = 0;
        while (fsm_state == 3'd3 && off_l < 5000) begin
            off_l++;
            if (off_l == 100) zcd_raw = 1'b1;
            if (off_l == 105) zcd_raw = 1'b0;
            if (off_l == FIXED_OFF - 5) zcd_raw = 1'b1;
            step();
        end
        check("R6 off-time with edges inside", off_l, FIXED_OFF);
        check("R6 state after late edge", int'(fsm_state), 4);
        repeat (20) step();
        check("R6 still waiting", int'(fsm_state), 4);
        check("R6 gate still low", int'(gate_on), 0);
        zcd_raw = 1'b0;
        step();

        // R7: fresh edge in WAIT_ZCD
        zcd_raw = 1'b1;
        wait_gate(20);
        zcd_raw = 1'b0;
        check("R7 restart from WAIT_ZCD", int'(fsm_state), 1);

        // R8: lockout during conduction
        repeat (3) step();
        uvlo = 1'b1;
        #1;
        check("R8 gate low same cycle", int'(gate_on), 0);
        step();
        check("R8 state IDLE", int'(fsm_state), 0);
        zcd_raw = 1'b1;
        repeat (4) step();
        zcd_raw = 1'b0;
        repeat (4) step();
        check("R8 edge ignored in lockout", int'(fsm_state), 0);
        check("R8 gate held low", int'(gate_on), 0);
        uvlo = 1'b0;
        step();
        check("R10 idle after fault clears", int'(fsm_state), 0);
        zcd_raw = 1'b1;
        wait_gate(20);
        zcd_raw = 1'b0;
        check("R10 edge starts ON_BLANK", int'(fsm_state), 1);

        // R9: over-temperature during conduction, then restart timeout
        repeat (30) step();
        check("R9 conducting before trip", int'(gate_on), 1);
        otp = 1'b1;
        #1;
        check("R9 gate low same cycle", int'(gate_on), 0);
        step();
        check("R9 state IDLE", int'(fsm_state), 0);
        repeat (5) step();
        otp = 1'b0;
        repeat (RESTART_CYC - 10) step();
        check("R10 no early restart", int'(fsm_state), 0);
        repeat (10) step();
        check("R10 timeout restart state", int'(fsm_state), 1);
        check("R10 timeout restart gate", int'(gate_on), 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule